// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-on to its operating state. After reset it waits for a start request. It then issues a fixed series of commands on a simple command interface, one command per valid cycle. Each command carries a command code, an address with the bank bits already placed at their correct position, and a mode-register value. The block needs a 1 µs tick for the long power-stabilisation wait. Every other wait is counted in clock cycles. When the series completes, it pulses a refresh-rate load strobe, raises a done flag, and hands the command interface to the normal command path.

The bit position of the bank field depends on the memory geometry. The configuration inputs give a column-count field, a row-count field, an interleaved/sequential decode select and the bus width. From these the block works out the bank-bit position.

The controller moves through these states in this order:
- `S_IDLE`
- `S_NOP1` (on start)
- `S_PWR`, left when the tick count reaches its target
- `S_NOP2`
- `S_PREA1`, `S_EMR2`, `S_EMR3`, `S_EMR1`
- `S_MRS_DLLRST`
- `S_PREA2`
- `S_REF1`, `S_REF2`
- `S_MRS_RUN`
- `S_EMR1_OCD`, `S_EMR1_EXIT`
- `S_NORMAL`
- `S_DUMMY`
- `S_RATE`
- `S_DONE`, a terminal state held until reset

From `S_NOP2` up to and including `S_NORMAL`, each command state passes through `S_GAP`, which returns to the next command state once the gap timer expires. `S_NOP1` goes straight to `S_PWR`. `S_DUMMY` goes straight to `S_RATE`.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: Out of reset and until start is seen, `cmd_valid`, `rate_load` and `init_done` are 0, `cmd_code` is NOP (0), and `cmd_addr` and `cmd_mode` are zero. The `us_tick` input and the `norm_*` inputs change none of these outputs. Every non-issue cycle before done shows the same NOP/zero values.
- R2: A start sampled high in idle issues a NOP in the next cycle. Ticks are then counted from the cycle after that NOP. The second NOP appears two cycles after the cycle that carries tick number `PWR_US` (default 200). The tick counter holds up to 1023.
- R3: After the second NOP the issued codes are, in this order:
  - precharge-all (1)
  - extended load (3) to bank 2, then to bank 3, then to bank 1
  - load mode (2)
  - precharge-all
  - auto-refresh (4), twice
  - load mode
  - extended load to bank 1, twice
  - normal (5)
  - dummy write (6)
- R4: Between two consecutive commands from the second NOP onward there are exactly `T_RP` (2) idle cycles after a precharge, `T_RFC` (16) after an auto-refresh, and `T_MRD` (2) after any other command.
- R5: The bank number sits in `cmd_addr` shifted left by an offset. The offset is the column field plus 9, plus the row field plus 11 (sequential decode only; the row term is dropped when `cfg_interleave`=1), plus 1 when `cfg_bus16`=1 or 2 otherwise. Commands without a bank use address 0.
- R6: `cmd_mode` values:
  - extended loads to banks 2 and 3: zero
  - first bank-1 extended load: `emr1_val` with bit 0 cleared (DLL on) and bits 9:7 = 000
  - first load mode: `mrs_val` with bit 8 (DLL reset) set
  - second load mode: `mrs_val` with bit 8 cleared
  - OCD-default extended load: bits 9:7 = 111
  - OCD-exit extended load: bits 9:7 = 000
  - all other commands: zero
- R7: `rate_load` is high for exactly the one cycle after the dummy write. `init_done` rises in the following cycle and stays high until reset.
- R8: While `init_done` is high, `cmd_valid`, `cmd_code` and `cmd_addr` follow `norm_valid`, `norm_code` and `norm_addr`, and `cmd_mode` is 0. Before done, the `norm_*` inputs have no effect.
- R9: A start pulse during the sequence or after done has no effect: one run issues exactly 15 commands. A reset mid-sequence returns the block to idle, and a new start runs the whole series again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the power-up series (used only in idle) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cfg_cols | input | COLF_W | Column-count field |
| cfg_rows | input | ROWF_W | Row-count field |
| cfg_interleave | input | 1 | 1 = interleaved bank decode, 0 = sequential |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| mrs_val | input | MODE_W | Base mode-register value |
| emr1_val | input | MODE_W | Base extended-mode-1 value (drive strength etc.) |
| norm_valid | input | 1 | Normal-path command valid |
| norm_code | input | 3 | Normal-path command code |
| norm_addr | input | ADDR_W | Normal-path command address |
| cmd_valid | output | 1 | Command valid this cycle |
| cmd_code | output | 3 | Command code |
| cmd_addr | output | ADDR_W | Address with placed bank bits |
| cmd_mode | output | MODE_W | Mode-register value |
| rate_load | output | 1 | One-cycle strobe to load the refresh rate |
| init_done | output | 1 | Initialization finished (sticky) |

## Verification
The hardest situations to reach are a start or reset that lands in the middle of the long tick wait or inside a gap. The behavioural model tracks a cycle countdown and a tick count, so pulses can be placed at arbitrary points and still be compared every cycle. The bench drives a second start during the tick wait. In a later run it asserts reset once five commands have been observed, then restarts. Three geometries (sequential with a 32-bit bus, interleaved with a 16-bit bus, sequential with a 16-bit bus) give three different bank offsets. Random traffic on the normal path runs throughout, both before and after done.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_PREA     = 3'd1,
        CMD_LMR      = 3'd2,
        CMD_EMR      = 3'd3,
        CMD_REF      = 3'd4,
        CMD_NORMAL   = 3'd5,
        CMD_DUMMY_WR = 3'd6
    } cmd_e;

    typedef enum logic [4:0] {
        S_IDLE,
        S_NOP1,
        S_PWR,
        S_NOP2,
        S_PREA1,
        S_EMR2,
        S_EMR3,
        S_EMR1,
        S_MRS_DLLRST,
        S_PREA2,
        S_REF1,
        S_REF2,
        S_MRS_RUN,
        S_EMR1_OCD,
        S_EMR1_EXIT,
        S_NORMAL,
        S_DUMMY,
        S_RATE,
        S_DONE,
        S_GAP
    } state_e;

    // Mode-register bit positions decoded by the memory device
    localparam int DLL_RST_BIT = 8;
    localparam int DLL_OFF_BIT = 0;
    localparam int OCD_LSB     = 7;
    localparam int OCD_W       = 3;
    localparam logic [OCD_W-1:0] OCD_DEFAULT = 3'b111;
    localparam logic [OCD_W-1:0] OCD_EXIT    = 3'b000;

endpackage

// File: rtl/ddr2_bank_pos.sv
module ddr2_bank_pos #(
    parameter int ADDR_W = 32,
    parameter int COLF_W = 2,
    parameter int ROWF_W = 2
) (
    input  logic [COLF_W-1:0] cfg_cols,
    input  logic [ROWF_W-1:0] cfg_rows,
    input  logic              cfg_interleave,
    input  logic              cfg_bus16,
    input  logic [1:0]        bank,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFF_W = $clog2(ADDR_W);

    logic [OFF_W-1:0] col_part;
    logic [OFF_W-1:0] row_part;
    logic [OFF_W-1:0] bus_part;
    logic [OFF_W-1:0] offset;

    always_comb begin
        col_part = OFF_W'(cfg_cols) + OFF_W'(9);
        row_part = cfg_interleave ? '0 : (OFF_W'(cfg_rows) + OFF_W'(11));
        bus_part = cfg_bus16 ? OFF_W'(1) : OFF_W'(2);
        offset   = col_part + row_part + bus_part;
        addr     = ADDR_W'(bank) << offset;
    end

endmodule

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R4
    gap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

endmodule

// File: rtl/ddr2_us_wait.sv
module ddr2_us_wait #(
    parameter int TARGET = 200,
    parameter int W      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    input  logic tick,
    output logic reached
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= '0;
        end else if (run && tick && !reached) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign reached = (cnt_q == W'(TARGET));

    // R2
    tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(arm) && cnt_q != $past(cnt_q)) |-> $past(run && tick));

endmodule

// File: rtl/ddr2_init_fsm.sv
module ddr2_init_fsm
    import ddr2_init_pkg::*;
#(
    parameter int MODE_W = 13,
    parameter int GAP_W  = 5,
    parameter int T_RP   = 2,
    parameter int T_MRD  = 2,
    parameter int T_RFC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              us_reached,
    input  logic              gap_zero,
    input  logic [MODE_W-1:0] mrs_val,
    input  logic [MODE_W-1:0] emr1_val,
    output logic              us_arm,
    output logic              us_run,
    output logic              gap_load,
    output logic [GAP_W-1:0]  gap_val,
    output logic              seq_valid,
    output cmd_e              seq_code,
    output logic [1:0]        seq_bank,
    output logic [MODE_W-1:0] seq_mode,
    output logic              rate_load,
    output logic              done
);
    state_e state_q, state_d;
    state_e ret_q, ret_d;

    logic [MODE_W-1:0] emr1_run, emr1_ocd, mrs_rst, mrs_run;

    // mode values derived from the base inputs
    always_comb begin
        emr1_run = emr1_val;
        emr1_run[DLL_OFF_BIT] = 1'b0;
        emr1_run[OCD_LSB +: OCD_W] = OCD_EXIT;
        emr1_ocd = emr1_run;
        emr1_ocd[OCD_LSB +: OCD_W] = OCD_DEFAULT;
        mrs_rst = mrs_val;
        mrs_rst[DLL_RST_BIT] = 1'b1;
        mrs_run = mrs_val;
        mrs_run[DLL_RST_BIT] = 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ret_q   <= S_IDLE;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        unique case (state_q)
            S_IDLE:       if (start) state_d = S_NOP1;
            S_NOP1:       state_d = S_PWR;
            S_PWR:        if (us_reached) state_d = S_NOP2;
            S_NOP2:       begin ret_d = S_PREA1;      state_d = S_GAP; end
            S_PREA1:      begin ret_d = S_EMR2;       state_d = S_GAP; end
            S_EMR2:       begin ret_d = S_EMR3;       state_d = S_GAP; end
            S_EMR3:       begin ret_d = S_EMR1;       state_d = S_GAP; end
            S_EMR1:       begin ret_d = S_MRS_DLLRST; state_d = S_GAP; end
            S_MRS_DLLRST: begin ret_d = S_PREA2;      state_d = S_GAP; end
            S_PREA2:      begin ret_d = S_REF1;       state_d = S_GAP; end
            S_REF1:       begin ret_d = S_REF2;       state_d = S_GAP; end
            S_REF2:       begin ret_d = S_MRS_RUN;    state_d = S_GAP; end
            S_MRS_RUN:    begin ret_d = S_EMR1_OCD;   state_d = S_GAP; end
            S_EMR1_OCD:   begin ret_d = S_EMR1_EXIT;  state_d = S_GAP; end
            S_EMR1_EXIT:  begin ret_d = S_NORMAL;     state_d = S_GAP; end
            S_NORMAL:     begin ret_d = S_DUMMY;      state_d = S_GAP; end
            S_GAP:        if (gap_zero) state_d = ret_q;
            S_DUMMY:      state_d = S_RATE;
            S_RATE:       state_d = S_DONE;
            S_DONE:       state_d = S_DONE;
            default:      state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        us_arm    = 1'b0;
        us_run    = 1'b0;
        gap_load  = 1'b0;
        gap_val   = GAP_W'(T_MRD - 1);
        seq_valid = 1'b0;
        seq_code  = CMD_NOP;
        seq_bank  = 2'd0;
        seq_mode  = '0;
        rate_load = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE, S_GAP: ;
            S_NOP1: begin
                seq_valid = 1'b1;
                us_arm    = 1'b1;
            end
            S_PWR:  us_run = 1'b1;
            S_NOP2: begin
                seq_valid = 1'b1;
                gap_load  = 1'b1;
            end
            S_PREA1, S_PREA2: begin
                seq_valid = 1'b1;
                seq_code  = CMD_PREA;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RP - 1);
            end
            S_EMR2: begin
                seq_valid = 1'b1;
                seq_code  = CMD_EMR;
                seq_bank  = 2'd2;
                gap_load  = 1'b1;
            end
            S_EMR3: begin
                seq_valid = 1'b1;
                seq_code  = CMD_EMR;
                seq_bank  = 2'd3;
                gap_load  = 1'b1;
            end
            S_EMR1, S_EMR1_EXIT: begin
                seq_valid = 1'b1;
                seq_code  = CMD_EMR;
                seq_bank  = 2'd1;
                seq_mode  = emr1_run;
                gap_load  = 1'b1;
            end
            S_EMR1_OCD: begin
                seq_valid = 1'b1;
                seq_code  = CMD_EMR;
                seq_bank  = 2'd1;
                seq_mode  = emr1_ocd;
                gap_load  = 1'b1;
            end
            S_MRS_DLLRST: begin
                seq_valid = 1'b1;
                seq_code  = CMD_LMR;
                seq_mode  = mrs_rst;
                gap_load  = 1'b1;
            end
            S_MRS_RUN: begin
                seq_valid = 1'b1;
                seq_code  = CMD_LMR;
                seq_mode  = mrs_run;
                gap_load  = 1'b1;
            end
            S_REF1, S_REF2: begin
                seq_valid = 1'b1;
                seq_code  = CMD_REF;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RFC - 1);
            end
            S_NORMAL: begin
                seq_valid = 1'b1;
                seq_code  = CMD_NORMAL;
                gap_load  = 1'b1;
            end
            S_DUMMY: begin
                seq_valid = 1'b1;
                seq_code  = CMD_DUMMY_WR;
            end
            S_RATE: rate_load = 1'b1;
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R2
    second_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_NOP2) |-> $past(us_reached));

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MODE_W   = 13,
    parameter int COLF_W   = 2,
    parameter int ROWF_W   = 2,
    parameter int PWR_US   = 200,
    parameter int US_CNT_W = 10,
    parameter int T_RP     = 2,
    parameter int T_MRD    = 2,
    parameter int T_RFC    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              us_tick,
    input  logic [COLF_W-1:0] cfg_cols,
    input  logic [ROWF_W-1:0] cfg_rows,
    input  logic              cfg_interleave,
    input  logic              cfg_bus16,
    input  logic [MODE_W-1:0] mrs_val,
    input  logic [MODE_W-1:0] emr1_val,
    input  logic              norm_valid,
    input  logic [2:0]        norm_code,
    input  logic [ADDR_W-1:0] norm_addr,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [MODE_W-1:0] cmd_mode,
    output logic              rate_load,
    output logic              init_done
);
    localparam int GAP_AB  = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_GAP = (GAP_AB > T_RFC) ? GAP_AB : T_RFC;
    localparam int GAP_W   = $clog2(MAX_GAP + 1);

    logic              us_arm, us_run, us_reached;
    logic              gap_load, gap_zero;
    logic [GAP_W-1:0]  gap_val;
    logic              seq_valid;
    cmd_e              seq_code;
    logic [1:0]        seq_bank;
    logic [MODE_W-1:0] seq_mode;
    logic [ADDR_W-1:0] seq_addr;

    ddr2_init_fsm #(
        .MODE_W (MODE_W),
        .GAP_W  (GAP_W),
        .T_RP   (T_RP),
        .T_MRD  (T_MRD),
        .T_RFC  (T_RFC)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .us_reached (us_reached),
        .gap_zero   (gap_zero),
        .mrs_val    (mrs_val),
        .emr1_val   (emr1_val),
        .us_arm     (us_arm),
        .us_run     (us_run),
        .gap_load   (gap_load),
        .gap_val    (gap_val),
        .seq_valid  (seq_valid),
        .seq_code   (seq_code),
        .seq_bank   (seq_bank),
        .seq_mode   (seq_mode),
        .rate_load  (rate_load),
        .done       (init_done)
    );

    ddr2_us_wait #(
        .TARGET (PWR_US),
        .W      (US_CNT_W)
    ) us_wait_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (us_arm),
        .run     (us_run),
        .tick    (us_tick),
        .reached (us_reached)
    );

    ddr2_gap_timer #(
        .W (GAP_W)
    ) gap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_zero)
    );

    ddr2_bank_pos #(
        .ADDR_W (ADDR_W),
        .COLF_W (COLF_W),
        .ROWF_W (ROWF_W)
    ) bank_i (
        .cfg_cols       (cfg_cols),
        .cfg_rows       (cfg_rows),
        .cfg_interleave (cfg_interleave),
        .cfg_bus16      (cfg_bus16),
        .bank           (seq_bank),
        .addr           (seq_addr)
    );

    // hand-over between sequencer and normal path
    always_comb begin
        if (init_done) begin
            cmd_valid = norm_valid;
            cmd_code  = norm_code;
            cmd_addr  = norm_addr;
            cmd_mode  = '0;
        end else begin
            cmd_valid = seq_valid;
            cmd_code  = 3'(seq_code);
            cmd_addr  = seq_addr;
            cmd_mode  = seq_mode;
        end
    end

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !cmd_valid) |-> (cmd_code == 3'(CMD_NOP) && cmd_addr == '0 && cmd_mode == '0));

    // R4
    spaced_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && cmd_valid) |=> !cmd_valid);

    // R7
    rate_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_load |=> (init_done && !rate_load));

endmodule

// File: tb/ddr2_pwrup_seq_tb.sv
module ddr2_pwrup_seq_tb_top;

    localparam int ADDR_W = 32;
    localparam int MODE_W = 13;
    localparam int PWR_US = 200;
    localparam int N_CMDS = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              us_tick = 1'b0;
    logic [1:0]        cfg_cols = 2'd0;
    logic [1:0]        cfg_rows = 2'd0;
    logic              cfg_interleave = 1'b0;
    logic              cfg_bus16 = 1'b0;
    logic [MODE_W-1:0] mrs_val = 13'h0152;
    logic [MODE_W-1:0] emr1_val = 13'h0383;
    logic              norm_valid = 1'b0;
    logic [2:0]        norm_code = 3'd0;
    logic [ADDR_W-1:0] norm_addr = '0;
    logic              cmd_valid;
    logic [2:0]        cmd_code;
    logic [ADDR_W-1:0] cmd_addr;
    logic [MODE_W-1:0] cmd_mode;
    logic              rate_load;
    logic              init_done;

    int checks = 0;
    int failures = 0;
    int obs_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ddr2_pwrup_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
        .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
        .cfg_interleave(cfg_interleave), .cfg_bus16(cfg_bus16),
        .mrs_val(mrs_val), .emr1_val(emr1_val),
        .norm_valid(norm_valid), .norm_code(norm_code), .norm_addr(norm_addr),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .cmd_mode(cmd_mode), .rate_load(rate_load), .init_done(init_done)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int code; int bank; int mode; } ent_t;
    ent_t q[$];
    typedef enum int { M_IDLE, M_PWR, M_RUN, M_RATE, M_DONE } mst_e;
    mst_e mst = M_IDLE;
    int idx = 0;
    int cd = 0;
    int ticks = 0;

    function automatic int gap_of(int code);
        if (code == 1) return 2;
        if (code == 4) return 16;
        return 2;
    endfunction

    function automatic int bank_off();
        int o;
        o = int'(cfg_cols) + 9;
        if (!cfg_interleave) o += int'(cfg_rows) + 11;
        o += cfg_bus16 ? 1 : 2;
        return o;
    endfunction

    task automatic push(int c, int b, int m);
        ent_t e;
        e.code = c; e.bank = b; e.mode = m;
        q.push_back(e);
    endtask

    task automatic build_q();
        int e1, mr;
        e1 = int'(emr1_val) & ~1 & ~(7 << 7);
        mr = int'(mrs_val);
        q.delete();
        push(0, 0, 0); push(0, 0, 0); push(1, 0, 0);
        push(3, 2, 0); push(3, 3, 0); push(3, 1, e1);
        push(2, 0, mr | 256); push(1, 0, 0);
        push(4, 0, 0); push(4, 0, 0);
        push(2, 0, mr & ~256);
        push(3, 1, e1 | (7 << 7)); push(3, 1, e1);
        push(5, 0, 0); push(6, 0, 0);
    endtask

    task automatic expect_quiet(string req);
        chk(req, "valid", cmd_valid, 0);
        chk(req, "code", cmd_code, 0);
        chk(req, "addr", cmd_addr, 0);
        chk(req, "mode", cmd_mode, 0);
        chk(req, "rate_load", rate_load, 0);
        chk(req, "done", init_done, 0);
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            expect_quiet("R1");
            mst = M_IDLE;
            obs_cnt = 0;
        end else begin
            if (cmd_valid && !init_done) obs_cnt++;
            case (mst)
                M_IDLE: begin
                    expect_quiet("R1");
                    if (start) begin build_q(); mst = M_RUN; idx = 0; cd = 0; end
                end
                M_PWR: begin
                    expect_quiet("R2");
                    if (ticks == PWR_US) begin mst = M_RUN; cd = 0; end
                    else if (us_tick) ticks++;
                end
                M_RUN: begin
                    if (cd == 0) begin
                        ent_t e;
                        e = q[idx];
                        chk(idx < 2 ? "R2" : "R3", "valid", cmd_valid, 1);
                        chk(idx < 2 ? "R2" : "R3", "code", cmd_code, e.code);
                        chk("R5", "addr", cmd_addr, 64'(e.bank) << bank_off());
                        chk("R6", "mode", cmd_mode, e.mode);
                        chk("R7", "done", init_done, 0);
                        idx++;
                        if (idx == 1) begin mst = M_PWR; ticks = 0; end
                        else if (idx == q.size()) mst = M_RATE;
                        else cd = gap_of(e.code);
                    end else begin
                        expect_quiet("R4");
                        cd--;
                    end
                end
                M_RATE: begin
                    chk("R7", "rate_load", rate_load, 1);
                    chk("R7", "done", init_done, 0);
                    chk("R7", "valid", cmd_valid, 0);
                    mst = M_DONE;
                end
                M_DONE: begin
                    chk("R7", "done", init_done, 1);
                    chk("R7", "rate_load", rate_load, 0);
                    chk("R8", "valid", cmd_valid, norm_valid);
                    chk("R8", "code", cmd_code, norm_code);
                    chk("R8", "addr", cmd_addr, norm_addr);
                    chk("R8", "mode", cmd_mode, 0);
                end
                default: ;
            endcase
        end
    end

    // microsecond tick: every fourth cycle
    initial begin
        int tc = 0;
        forever begin
            @(posedge clk); #2;
            us_tick = (tc % 4 == 3);
            tc++;
        end
    end

    // normal-path traffic, active at all times (R8: ignored before done)
    initial begin
        forever begin
            @(posedge clk); #2;
            norm_valid = 1'($urandom);
            norm_code  = 3'($urandom);
            norm_addr  = $urandom;
        end
    end

    task automatic pulse_start();
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic finish_run();
        wait (init_done);
        @(negedge clk);
        // R9: exactly one series of commands per run
        chk("R9", "issued", obs_cnt, N_CMDS);
        pulse_start();
        repeat (30) @(posedge clk);
    endtask

    initial begin
        // run A: sequential decode, 32-bit bus, offset 25
        cfg_cols = 2'd1; cfg_rows = 2'd2; cfg_interleave = 1'b0; cfg_bus16 = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (20) @(posedge clk);
        pulse_start();
        repeat (60) @(posedge clk);
        pulse_start();              // R9: ignored during the tick wait
        finish_run();

        // run B: interleaved decode, 16-bit bus, offset 13, reset mid-run
        do_reset();
        cfg_cols = 2'd3; cfg_rows = 2'd3; cfg_interleave = 1'b1; cfg_bus16 = 1'b1;
        mrs_val = 13'h0033; emr1_val = 13'h0042;
        pulse_start();
        while (obs_cnt < 5) @(negedge clk);
        @(posedge clk); #2 rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "valid after reset", cmd_valid, 0);
        chk("R9", "done after reset", init_done, 0);
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        pulse_start();
        finish_run();

        // run C: sequential decode, 16-bit bus, offset 21
        do_reset();
        cfg_cols = 2'd0; cfg_rows = 2'd0; cfg_interleave = 1'b0; cfg_bus16 = 1'b1;
        mrs_val = 13'h1fff; emr1_val = 13'h0000;
        pulse_start();
        finish_run();

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule